// File: doc/BRIEF.md
# Full-Duplex Pause Flow Control Handler

This block handles MAC-control flow control for one full-duplex Ethernet port. A receive parser watches the byte stream from the MAC receive path and picks out pause frames. The criteria are the reserved multicast destination, the MAC-control length/type value and the pause opcode. From each such frame it takes the 16-bit pause time. A timer then counts that time down in quanta, where one quantum is a parameterised number of bit times. Bit times come from an input strobe, so the same logic serves a 10 Mbit/s port and a 100 Mbit/s port.

While the timer is non-zero, a transmit gate refuses requests to start a new data frame. A frame already on the wire is not the gate's concern. A second path builds a pause frame of its own when a congestion request arrives. It emits destination, source (from a device-address input), type, opcode, time and zero padding as a byte stream with a valid/ready handshake. The adjacent MAC stage appends and checks the FCS.

Top module: `pause_ctl`

## Requirements
- R1: After reset, `paused` and `gen_valid` are 0, and `data_start_ok` follows `data_start`.
- R2: A received frame is accepted as a pause frame only when all of the following hold: it starts with `rx_sof`; its bytes 0..5 are 01 80 C2 00 00 01; bytes 12..13 are 88 08; bytes 14..15 are 00 01; and it is at least 19 bytes long. The pause time is bytes 16 (high) and 17 (low). The timer takes the time on the clock edge that samples the byte carrying `rx_eof`.
- R3: A frame that differs in destination, type or opcode, or that is shorter than 19 bytes, leaves the timer unchanged.
- R4: A loaded time of N releases `paused` after exactly N×QUANTUM_BITS sampled `bit_tick` pulses.
- R5: A newly accepted pause frame replaces the remaining time outright and restarts the current quantum.
- R6: An accepted pause time of zero clears `paused` on the same edge.
- R7: While `pause_en` is 0, the timer is forced to zero on the next edge and accepted frames do not load it.
- R8: `data_start_ok` is `data_start` gated by `paused`. The gate closes from the cycle after the end-of-frame byte of an accepted non-zero pause frame.
- R9: A congestion request with a non-zero `gen_time` produces one frame of MIN_FRAME bytes. Bytes 0..5 are 01 80 C2 00 00 01. Bytes 6..11 are `dev_addr`, most significant byte first. Bytes 12..15 are 88 08 00 01. Bytes 16..17 are the time, high byte first. All remaining bytes are zero. `gen_sof` marks byte 0 and `gen_eof` marks the last byte.
- R10: A generated byte stays on `gen_data` until `gen_ready` accepts it. A request made while a frame is being sent is ignored, and so is a request with a zero time.
- R11: Without `bit_tick`, the timer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per line bit time |
| pause_en | input | 1 | Negotiated pause capability |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| data_start | input | 1 | Request to start a new data frame |
| data_start_ok | output | 1 | Start permitted |
| paused | output | 1 | Pause timer running |
| dev_addr | input | 48 | Station address for generated frames |
| gen_req | input | 1 | Congestion request pulse |
| gen_time | input | 16 | Pause time to advertise |
| gen_ready | input | 1 | Downstream accepts a generated byte |
| gen_valid | output | 1 | Generated byte valid |
| gen_data | output | 8 | Generated byte |
| gen_sof | output | 1 | First generated byte |
| gen_eof | output | 1 | Last generated byte |

## Verification
The bench builds the block with QUANTUM_BITS set to 8, so a quantum lasts eight strobes. This keeps multi-quantum countdowns, mid-quantum replacement and the exact release edge within a few dozen cycles. MIN_FRAME keeps its default of 60, so the generated frame covers the full header, the padding and the end marker. A stalling ready pattern exercises the hold behaviour of the output stream.

// File: rtl/pause_pkg.sv
package pause_pkg;
    // bytes of a received frame needed to hold the whole control header
    localparam int HDR_BYTES = 18;

    typedef enum logic {G_IDLE, G_SEND} gen_st_e;

    // constant header bytes at fixed offsets; zero elsewhere (also the pad value)
    function automatic logic [7:0] fixed_byte(input int unsigned idx);
        case (idx)
            0:       fixed_byte = 8'h01;
            1:       fixed_byte = 8'h80;
            2:       fixed_byte = 8'hC2;
            5:       fixed_byte = 8'h01;
            12:      fixed_byte = 8'h88;
            13:      fixed_byte = 8'h08;
            15:      fixed_byte = 8'h01;
            default: fixed_byte = 8'h00;
        endcase
    endfunction

    function automatic logic is_fixed(input int unsigned idx);
        is_fixed = (idx < 6) || (idx >= 12 && idx < 16);
    endfunction
endpackage

// File: rtl/pause_rx_parse.sv
module pause_rx_parse
    import pause_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    output logic        load,
    output logic [15:0] load_val
);
    localparam int CNT_W = $clog2(HDR_BYTES + 1);
    localparam logic [CNT_W-1:0] HDR_C = CNT_W'(HDR_BYTES);

    typedef struct packed {
        logic             in_frame;
        logic             match;
        logic [CNT_W-1:0] cnt;
        logic [15:0]      tval;
    } prs_t;

    prs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (rx_valid) begin
            if (rx_sof) begin
                st_d.in_frame = !rx_eof;
                st_d.cnt      = CNT_W'(1);
                st_d.match    = (rx_data == fixed_byte(0));
                st_d.tval     = '0;
            end else if (st_q.in_frame) begin
                if (st_q.cnt < HDR_C) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                    if (is_fixed(int'(st_q.cnt)))
                        st_d.match = st_q.match && (rx_data == fixed_byte(int'(st_q.cnt)));
                    if (int'(st_q.cnt) == 16) st_d.tval[15:8] = rx_data;
                    if (int'(st_q.cnt) == 17) st_d.tval[7:0]  = rx_data;
                end
                if (rx_eof) begin
                    st_d.in_frame = 1'b0;
                    load = st_q.match && (st_q.cnt == HDR_C);
                end
            end
        end
    end

    assign load_val = st_q.tval;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the byte counter never runs past the header length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= HDR_C);
endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
    parameter int QUANTUM_BITS = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        pause_en,
    input  logic        load,
    input  logic [15:0] load_val,
    output logic        paused
);
    localparam int SUB_W = (QUANTUM_BITS > 2) ? $clog2(QUANTUM_BITS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(QUANTUM_BITS - 1);

    typedef struct packed {
        logic [15:0]      quanta;
        logic [SUB_W-1:0] sub;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pause_en) begin
            st_d.quanta = '0;
            st_d.sub    = '0;
        end else if (load) begin
            st_d.quanta = load_val;
            st_d.sub    = '0;
        end else if (bit_tick && st_q.quanta != '0) begin
            if (st_q.sub == SUB_LAST) begin
                st_d.sub    = '0;
                st_d.quanta = st_q.quanta - 16'd1;
            end else begin
                st_d.sub = st_q.sub + SUB_W'(1);
            end
        end
    end

    assign paused = (st_q.quanta != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: losing pause capability empties the timer on the next edge
    p_cap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_en |=> st_q.quanta == '0);
    // R5: an accepted frame sets the remaining time to its own value
    p_replace_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_en && load) |=> st_q.quanta == $past(load_val));
    // R4: without a load the count only goes down
    p_down_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_en && !load) |=> st_q.quanta <= $past(st_q.quanta));
    // R11: no strobe, no movement
    p_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_en && !load && !bit_tick) |=> $stable(st_q.quanta) && $stable(st_q.sub));
endmodule

// File: rtl/pause_tx_gen.sv
module pause_tx_gen
    import pause_pkg::*;
#(
    parameter int MIN_FRAME = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gen_req,
    input  logic [15:0] gen_time,
    input  logic [47:0] dev_addr,
    input  logic        gen_ready,
    output logic        gen_valid,
    output logic [7:0]  gen_data,
    output logic        gen_sof,
    output logic        gen_eof
);
    localparam int IDX_W = $clog2(MIN_FRAME);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(MIN_FRAME - 1);

    typedef struct packed {
        gen_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [47:0]      addr;
        logic [15:0]      tval;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            G_IDLE: if (gen_req && gen_time != '0) begin
                st_d.st   = G_SEND;
                st_d.idx  = '0;
                st_d.addr = dev_addr;
                st_d.tval = gen_time;
            end
            G_SEND: if (gen_ready) begin
                if (st_q.idx == LAST) begin
                    st_d.st  = G_IDLE;
                    st_d.idx = '0;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
            default: st_d.st = G_IDLE;
        endcase
    end

    // byte selection by position in the frame
    always_comb begin
        int unsigned i;
        logic [47:0] sh;
        i  = int'(st_q.idx);
        sh = '0;
        if (is_fixed(i)) begin
            gen_data = fixed_byte(i);
        end else if (i >= 6 && i < 12) begin
            sh       = st_q.addr << (8 * (i - 6));
            gen_data = sh[47:40];
        end else if (i == 16) begin
            gen_data = st_q.tval[15:8];
        end else if (i == 17) begin
            gen_data = st_q.tval[7:0];
        end else begin
            gen_data = 8'h00;
        end
    end

    assign gen_valid = (st_q.st == G_SEND);
    assign gen_sof   = gen_valid && (st_q.idx == '0);
    assign gen_eof   = gen_valid && (st_q.idx == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: G_IDLE, idx: '0, addr: '0, tval: '0};
        else        st_q <= st_d;
    end

    // R10: a stalled byte is held unchanged
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid && !gen_ready) |=> gen_valid && $stable(gen_data) && $stable(gen_sof) && $stable(gen_eof));
    // R9: exactly one frame per request, so the stream stops after its last byte
    p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid && gen_ready && gen_eof) |=> !gen_valid);
endmodule

// File: rtl/pause_ctl.sv
module pause_ctl #(
    parameter int QUANTUM_BITS = 512,
    parameter int MIN_FRAME    = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        pause_en,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        data_start,
    output logic        data_start_ok,
    output logic        paused,
    input  logic [47:0] dev_addr,
    input  logic        gen_req,
    input  logic [15:0] gen_time,
    input  logic        gen_ready,
    output logic        gen_valid,
    output logic [7:0]  gen_data,
    output logic        gen_sof,
    output logic        gen_eof
);
    logic        ld;
    logic [15:0] ld_val;

    pause_rx_parse u_parse (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .load(ld), .load_val(ld_val)
    );

    pause_timer #(.QUANTUM_BITS(QUANTUM_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .pause_en(pause_en),
        .load(ld), .load_val(ld_val), .paused(paused)
    );

    pause_tx_gen #(.MIN_FRAME(MIN_FRAME)) u_gen (
        .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_time(gen_time),
        .dev_addr(dev_addr), .gen_ready(gen_ready), .gen_valid(gen_valid),
        .gen_data(gen_data), .gen_sof(gen_sof), .gen_eof(gen_eof)
    );

    // only the start of a new data frame is gated
    assign data_start_ok = data_start && !paused;

    // R8: an accepted non-zero pause closes the gate on the very next cycle
    p_gate_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_en && ld && ld_val != '0) |=> !data_start_ok);
endmodule

// File: tb/tb_pause_ctl.sv
module tb_pause_ctl;
    localparam int QB = 8;
    localparam int MF = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, pause_en = 1'b1;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        data_start = 1'b1;
    logic        data_start_ok, paused;
    logic [47:0] dev_addr = '0;
    logic        gen_req = 1'b0;
    logic [15:0] gen_time = '0;
    logic        gen_ready;
    logic        gen_valid, gen_sof, gen_eof;
    logic [7:0]  gen_data;

    int  n_run = 0, n_fail = 0, frames_seen = 0, cyc = 0;
    bit  stall_mode = 1'b0, done = 1'b0;
    logic [9:0] exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign gen_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;

    pause_ctl #(.QUANTUM_BITS(QB), .MIN_FRAME(MF)) dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .pause_en(pause_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .data_start(data_start), .data_start_ok(data_start_ok), .paused(paused),
        .dev_addr(dev_addr), .gen_req(gen_req), .gen_time(gen_time),
        .gen_ready(gen_ready), .gen_valid(gen_valid), .gen_data(gen_data),
        .gen_sof(gen_sof), .gen_eof(gen_eof)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [47:0] da, input logic [15:0] typ,
                              input logic [15:0] op, input logic [15:0] tm, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            if (i < 6)       rx_data = da[47 - 8*i -: 8];
            else if (i < 12) rx_data = 8'hAA;
            else if (i < 14) rx_data = typ[15 - 8*(i-12) -: 8];
            else if (i < 16) rx_data = op[15 - 8*(i-14) -: 8];
            else if (i < 18) rx_data = tm[15 - 8*(i-16) -: 8];
            else             rx_data = 8'(i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic pause_frame(input logic [15:0] tm);
        send_frame(48'h0180C2000001, 16'h8808, 16'h0001, tm, 64);
    endtask

    task automatic run_ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) @(negedge clk);
        bit_tick = 1'b0;
    endtask

    // driver: predicts the generated frame then issues the request
    task automatic gen_frame(input logic [47:0] addr, input logic [15:0] tm);
        for (int i = 0; i < MF; i++) begin
            logic [7:0] b;
            case (i)
                0: b = 8'h01; 1: b = 8'h80; 2: b = 8'hC2; 3: b = 8'h00; 4: b = 8'h00; 5: b = 8'h01;
                12: b = 8'h88; 13: b = 8'h08; 14: b = 8'h00; 15: b = 8'h01;
                16: b = tm[15:8]; 17: b = tm[7:0];
                default: b = (i >= 6 && i < 12) ? addr[47 - 8*(i-6) -: 8] : 8'h00;
            endcase
            exp_q.push_back({(i == 0), (i == MF - 1), b});
        end
        @(negedge clk);
        dev_addr = addr; gen_time = tm; gen_req = 1'b1;
        @(negedge clk);
        gen_req = 1'b0; dev_addr = 48'hFFFF_FFFF_FFFF; gen_time = 16'hBEEF;
    endtask

    task automatic drain();
        for (int k = 0; k < 1000 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops predicted bytes as the stream is accepted (R9, R10)
    always @(negedge clk) begin
        if (rst_n && gen_valid && gen_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected byte", {gen_sof, gen_eof, gen_data}, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check({gen_sof, gen_eof, gen_data} == e, "R9 generated byte",
                      {gen_sof, gen_eof, gen_data}, e);
            end
            if (gen_eof) frames_seen++;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(paused == 0, "R1 paused", paused, 0);
        check(gen_valid == 0, "R1 gen_valid", gen_valid, 0);
        check(data_start_ok == 1, "R1 gate open", data_start_ok, 1);

        // R2/R8 accept a pause of 3 quanta
        pause_frame(16'd3);
        check(paused == 1, "R2 pause accepted", paused, 1);
        check(data_start_ok == 0, "R8 gate closed", data_start_ok, 0);
        // R11 no strobe, no countdown
        repeat (10) @(negedge clk);
        check(paused == 1, "R11 hold without tick", paused, 1);
        // R4 exact expiry
        run_ticks(3*QB - 1);
        check(paused == 1, "R4 one tick early", paused, 1);
        run_ticks(1);
        check(paused == 0, "R4 released", paused, 0);
        check(data_start_ok == 1, "R8 gate reopened", data_start_ok, 1);

        // R3 non-matching frames
        send_frame(48'h0180C2000002, 16'h8808, 16'h0001, 16'd5, 64);
        check(paused == 0, "R3 wrong DA", paused, 0);
        send_frame(48'h0180C2000001, 16'h0800, 16'h0001, 16'd5, 64);
        check(paused == 0, "R3 wrong type", paused, 0);
        send_frame(48'h0180C2000001, 16'h8808, 16'h0002, 16'd5, 64);
        check(paused == 0, "R3 wrong opcode", paused, 0);
        send_frame(48'h0180C2000001, 16'h8808, 16'h0001, 16'd5, 18);
        check(paused == 0, "R3 short frame", paused, 0);
        send_frame(48'h0180C2000001, 16'h8808, 16'h0001, 16'd1, 19);
        check(paused == 1, "R2 19-byte frame accepted", paused, 1);
        run_ticks(QB);
        check(paused == 0, "R4 single quantum", paused, 0);

        // R5 replace downward mid-quantum
        pause_frame(16'd10);
        run_ticks(2*QB + 4);
        pause_frame(16'd2);
        run_ticks(2*QB - 1);
        check(paused == 1, "R5 replaced time not yet over", paused, 1);
        run_ticks(1);
        check(paused == 0, "R5 replaced time over", paused, 0);
        // R5 replace upward
        pause_frame(16'd1);
        run_ticks(4);
        pause_frame(16'd4);
        run_ticks(4*QB - 1);
        check(paused == 1, "R5 extended", paused, 1);
        run_ticks(1);
        check(paused == 0, "R5 extended over", paused, 0);

        // R6 zero clears
        pause_frame(16'd7);
        check(paused == 1, "R6 preload", paused, 1);
        pause_frame(16'd0);
        check(paused == 0, "R6 zero clears", paused, 0);

        // R7 capability loss
        pause_frame(16'd7);
        pause_en = 1'b0;
        @(negedge clk);
        check(paused == 0, "R7 expire on capability loss", paused, 0);
        pause_frame(16'd5);
        check(paused == 0, "R7 load ignored", paused, 0);
        pause_en = 1'b1;
        @(negedge clk);

        // R9/R10 generated frames, stalled, with an ignored mid-frame request
        stall_mode = 1'b1;
        gen_frame(48'h0A1B2C3D4E5F, 16'h1234);
        repeat (20) @(negedge clk);
        gen_time = 16'h5555; dev_addr = 48'h112233445566; gen_req = 1'b1;
        @(negedge clk);
        gen_req = 1'b0;
        drain();
        check(gen_valid == 0 && exp_q.size() == 0, "R10 busy request ignored", gen_valid, 0);
        check(frames_seen == 1, "R9 one frame", frames_seen, 1);
        // R10 zero time ignored
        @(negedge clk);
        gen_time = 16'h0000; gen_req = 1'b1;
        @(negedge clk);
        gen_req = 1'b0;
        repeat (5) @(negedge clk);
        check(gen_valid == 0, "R10 zero time ignored", gen_valid, 0);
        stall_mode = 1'b0;
        gen_frame(48'hF0E1D2C3B4A5, 16'hFFFF);
        drain();
        check(frames_seen == 2 && exp_q.size() == 0, "R9 second frame", frames_seen, 2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule